// File: doc/BRIEF.md
# Fractional Serial Clock Generator

This block derives the master serial clock of a serial peripheral interface from a 100 MHz system clock. Instead of a fixed integer divider it uses a phase accumulator: on every system clock the accumulator advances by twice the programmed 12-bit increment, modulo 4096. Each wrap toggles the serial clock. The mean serial clock frequency is therefore increment × 100 MHz / 4096, up to 50 MHz at increment 0x800. Rates that are not 100 MHz divided by an even integer give half-periods that alternate between neighbouring whole numbers of system cycles. This jitter is expected.

The increment can be written directly. It can also be loaded from a 16-entry table of legacy rates selected by a 4-bit speed code, from 0.025 MHz up to 50 MHz. The stored speed code can be read back, but it is only updated by a table load, so after a direct write it may no longer describe the active rate. Clock polarity sets the idle level. The shift logic receives two strobes, each one system clock wide. The primary strobe marks the edge that leaves the idle level and the secondary strobe marks the edge that returns to it.

Top module: `frac_sck_gen`

## Requirements
- R1: While enabled, each cycle adds 2 × the active increment to a 12-bit accumulator. SCK toggles at the clock edge where the sum reaches or passes 4096. The remainder modulo 4096 is kept.
- R2: An active increment of 0x800 toggles SCK on every enabled system clock, which is the 50 MHz maximum.
- R3: Active increments above 0x800 behave exactly like 0x800.
- R4: While enable is low, the accumulator is held at zero, SCK equals the polarity input one cycle later, and both strobes are low.
- R5: After enable rises, the first SCK toggle takes the full number of cycles for the increment (increment 0x400 gives its first toggle on the second enabled edge).
- R6: With polarity 0, SCK idles low and the primary edge is rising. With polarity 1, SCK idles high and the primary edge is falling. The primary strobe accompanies every toggle away from the idle level.
- R7: The primary and secondary strobes are never high together. Each strobe is high for exactly the one cycle in which SCK shows its new level.
- R8: A speed-code load sets the active increment to round(f × 4096 / 100 MHz) and stores the code. The resulting increments for codes 0 to 15 are 1, 2, 4, 8, 20, 41, 51, 82, 102, 137, 205, 410, 512, 683, 1024 and 2048, visible one cycle after the load.
- R9: A direct increment write changes the active increment one cycle later and leaves the stored speed code unchanged.
- R10: When a speed-code load and a direct write arrive in the same cycle, the speed-code load decides the increment.
- R11: An active increment of zero never toggles SCK.
- R12: Increment 0x4CC produces half-periods of 1 or 2 system cycles with a long-run mean near 30 MHz.
- R13: During reset, SCK follows the polarity input, the strobes are low, and the active increment and stored code are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds SCK idle |
| cpol | input | 1 | Clock polarity (idle level of SCK) |
| inc_in | input | 12 | Increment value for a direct write |
| inc_wr | input | 1 | Direct increment write strobe |
| spd_code | input | 4 | Legacy speed code |
| spd_wr | input | 1 | Legacy speed-code load strobe |
| sck | output | 1 | Serial clock level |
| pri_edge | output | 1 | Primary-edge strobe |
| sec_edge | output | 1 | Secondary-edge strobe |
| inc_cur | output | 12 | Active increment |
| spd_code_q | output | 4 | Stored speed code (may be stale) |

## Verification
The bench builds the block with its defaults: a 12-bit increment and a 100 MHz system rate. At these values, increment 0x800 reaches exact full rate, every legacy table entry can be compared against fixed rounded integers, and 0x4CC shows the alternating 1/2-cycle half-periods. Directed runs cover each polarity, disabling, restarting, zero and over-range increments, and colliding loads. Random increments, enables and loads then run for several thousand cycles against a cycle model of the accumulator, with every output compared on every cycle.

// File: rtl/fsck_pkg.sv
package fsck_pkg;

  localparam int unsigned CODE_W    = 4;
  localparam int unsigned SPD_CODES = 1 << CODE_W;

  // Legacy rate for each speed code, in Hz.
  function automatic longint unsigned spd_hz(input int unsigned code);
    case (code)
      0:       return 64'd25_000;
      1:       return 64'd50_000;
      2:       return 64'd100_000;
      3:       return 64'd200_000;
      4:       return 64'd500_000;
      5:       return 64'd1_000_000;
      6:       return 64'd1_250_000;
      7:       return 64'd2_000_000;
      8:       return 64'd2_500_000;
      9:       return 64'd3_333_333;
      10:      return 64'd5_000_000;
      11:      return 64'd10_000_000;
      12:      return 64'd12_500_000;
      13:      return 64'd16_666_667;
      14:      return 64'd25_000_000;
      default: return 64'd50_000_000;
    endcase
  endfunction

  // Rounded increment for a code: f * 2^acc_w / sys_hz
  function automatic int unsigned spd_incr(input int unsigned code,
                                           input int unsigned acc_w,
                                           input longint unsigned sys_hz);
    longint unsigned num;
    num = spd_hz(code) * (64'd1 << acc_w);
    return int'((num + sys_hz / 2) / sys_hz);
  endfunction

endpackage

// File: rtl/fsck_rate_reg.sv
module fsck_rate_reg #(
  parameter int unsigned     INC_W  = 12,
  parameter longint unsigned SYS_HZ = 100_000_000
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [INC_W-1:0]            inc_in,
  input  logic                        inc_wr,
  input  logic [fsck_pkg::CODE_W-1:0] spd_code,
  input  logic                        spd_wr,
  output logic [INC_W-1:0]            inc_q,
  output logic [fsck_pkg::CODE_W-1:0] code_q
);
  import fsck_pkg::*;

  logic [INC_W-1:0] preset [SPD_CODES];

  // Preset increments computed from the legacy rate list
  for (genvar g = 0; g < SPD_CODES; g++) begin : g_preset
    assign preset[g] = INC_W'(spd_incr(g, INC_W, SYS_HZ));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inc_q  <= '0;
      code_q <= '0;
    end else if (spd_wr) begin
      inc_q  <= preset[spd_code];
      code_q <= spd_code;
    end else if (inc_wr) begin
      inc_q  <= inc_in;
    end
  end

  a_r9_code_kept: assert property (@(posedge clk) disable iff (rst)
    (inc_wr && !spd_wr) |=> $stable(code_q));
  a_r8_code_stored: assert property (@(posedge clk) disable iff (rst)
    spd_wr |=> (code_q == $past(spd_code)));
  a_r9_direct_value: assert property (@(posedge clk) disable iff (rst)
    (inc_wr && !spd_wr) |=> (inc_q == $past(inc_in)));

endmodule

// File: rtl/fsck_accum.sv
module fsck_accum #(
  parameter int unsigned INC_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  output logic             toggle
);
  localparam logic [INC_W-1:0] MAX_INC = INC_W'(1 << (INC_W - 1));

  logic [INC_W-1:0] acc_q;
  logic [INC_W-1:0] inc_sat;
  logic [INC_W:0]   step;
  logic [INC_W:0]   sum;

  always_comb begin
    inc_sat = (inc > MAX_INC) ? MAX_INC : inc;
    step    = {inc_sat, 1'b0};
    sum     = {1'b0, acc_q} + step;
    toggle  = en & sum[INC_W];
  end

  always_ff @(posedge clk) begin
    if (rst || !en) acc_q <= '0;
    else            acc_q <= sum[INC_W-1:0];
  end

  a_r4_acc_zero: assert property (@(posedge clk) disable iff (rst)
    !en |=> (acc_q == '0));
  a_r2_full_rate: assert property (@(posedge clk) disable iff (rst)
    (en && inc >= MAX_INC) |-> toggle);
  a_r11_zero_quiet: assert property (@(posedge clk) disable iff (rst)
    (inc == '0) |-> !toggle);

endmodule

// File: rtl/fsck_edge_gen.sv
module fsck_edge_gen (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic cpol,
  input  logic toggle,
  output logic sck_q,
  output logic pri_q,
  output logic sec_q
);
  logic phase_q;
  logic phase_nx;

  always_comb phase_nx = en ? (phase_q ^ toggle) : 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      sck_q   <= cpol;
      pri_q   <= 1'b0;
      sec_q   <= 1'b0;
    end else begin
      phase_q <= phase_nx;
      sck_q   <= cpol ^ phase_nx;
      pri_q   <= en & toggle & ~phase_q;
      sec_q   <= en & toggle & phase_q;
    end
  end

  a_r7_strobe_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pri_q, sec_q}));
  a_r6_primary_leaves_idle: assert property (@(posedge clk) disable iff (rst)
    pri_q |-> (sck_q != $past(cpol)));
  a_r6_secondary_returns: assert property (@(posedge clk) disable iff (rst)
    sec_q |-> (sck_q == $past(cpol)));
  a_r4_idle_level: assert property (@(posedge clk) disable iff (rst)
    !en |=> (sck_q == $past(cpol) && !pri_q && !sec_q));

endmodule

// File: rtl/frac_sck_gen.sv
module frac_sck_gen #(
  parameter int unsigned     INC_W  = 12,
  parameter longint unsigned SYS_HZ = 100_000_000
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en,
  input  logic                        cpol,
  input  logic [INC_W-1:0]            inc_in,
  input  logic                        inc_wr,
  input  logic [fsck_pkg::CODE_W-1:0] spd_code,
  input  logic                        spd_wr,
  output logic                        sck,
  output logic                        pri_edge,
  output logic                        sec_edge,
  output logic [INC_W-1:0]            inc_cur,
  output logic [fsck_pkg::CODE_W-1:0] spd_code_q
);
  logic toggle;

  fsck_rate_reg #(.INC_W(INC_W), .SYS_HZ(SYS_HZ)) u_rate (
    .clk(clk), .rst(rst), .inc_in(inc_in), .inc_wr(inc_wr),
    .spd_code(spd_code), .spd_wr(spd_wr),
    .inc_q(inc_cur), .code_q(spd_code_q)
  );

  fsck_accum #(.INC_W(INC_W)) u_acc (
    .clk(clk), .rst(rst), .en(en), .inc(inc_cur), .toggle(toggle)
  );

  fsck_edge_gen u_edge (
    .clk(clk), .rst(rst), .en(en), .cpol(cpol), .toggle(toggle),
    .sck_q(sck), .pri_q(pri_edge), .sec_q(sec_edge)
  );

  a_r7_edge_changes_sck: assert property (@(posedge clk) disable iff (rst)
    ((pri_edge || sec_edge) && $stable(cpol)) |-> (sck != $past(sck)));

endmodule

// File: tb/frac_sck_gen_test.sv
module frac_sck_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0, cpol = 1'b0, inc_wr = 1'b0, spd_wr = 1'b0;
  logic [11:0] inc_in = '0;
  logic [3:0]  spd_code = '0;
  logic        sck, pri_edge, sec_edge;
  logic [11:0] inc_cur;
  logic [3:0]  spd_code_q;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // model state
  int m_acc = 0, m_inc = 0, m_code = 0;
  bit m_phase = 0;

  always #2.5 clk = ~clk;

  frac_sck_gen uut (
    .clk(clk), .rst(rst), .en(en), .cpol(cpol), .inc_in(inc_in),
    .inc_wr(inc_wr), .spd_code(spd_code), .spd_wr(spd_wr), .sck(sck),
    .pri_edge(pri_edge), .sec_edge(sec_edge), .inc_cur(inc_cur),
    .spd_code_q(spd_code_q)
  );

  function automatic int table_inc(input int c);
    int t [16] = '{1, 2, 4, 8, 20, 41, 51, 82, 102, 137, 205, 410, 512, 683, 1024, 2048};
    return t[c];
  endfunction

  task automatic chk(input string tag, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  // One clock: compute expected outputs from current inputs, then compare.
  task automatic cyc(input string tag);
    int stepv, sum, e_sck;
    bit tog, e_pri, e_sec;
    stepv = ((m_inc > 2048) ? 2048 : m_inc) * 2;
    if (en) begin
      sum = m_acc + stepv;
      tog = (sum >= 4096);
      e_pri = tog && !m_phase;
      e_sec = tog && m_phase;
      m_acc = sum % 4096;
      m_phase = m_phase ^ tog;
    end else begin
      m_acc = 0; m_phase = 0; e_pri = 0; e_sec = 0;
    end
    e_sck = cpol ^ m_phase;
    if (spd_wr) begin
      m_inc = table_inc(spd_code);
      m_code = spd_code;
    end else if (inc_wr) m_inc = inc_in;
    @(posedge clk); #1;
    chk(tag, "sck", sck, e_sck);
    chk(tag, "pri_edge", pri_edge, e_pri);
    chk(tag, "sec_edge", sec_edge, e_sec);
    chk(tag, "inc_cur", inc_cur, m_inc);
    chk(tag, "spd_code_q", spd_code_q, m_code);
    inc_wr = 0; spd_wr = 0;
  endtask

  task automatic set_inc(input int v, input string tag);
    inc_in = 12'(v); inc_wr = 1; cyc(tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int hp, last, mx, mn, toggles;
    void'($urandom(32'd4242));
    // R13: reset state, both polarities
    cpol = 1;
    repeat (3) @(posedge clk);
    #1;
    chk("R13", "sck", sck, 1); chk("R13", "pri_edge", pri_edge, 0);
    chk("R13", "inc_cur", inc_cur, 0); chk("R13", "spd_code_q", spd_code_q, 0);
    cpol = 0;
    @(posedge clk); #1;
    chk("R13", "sck", sck, 0);
    rst = 0;

    // R11: zero increment, enabled, never toggles
    en = 1;
    repeat (20) cyc("R11");
    // R2: full rate, polarity 0
    en = 0; set_inc(12'h800, "R2");
    en = 1;
    repeat (12) cyc("R2");
    // R3: over-range increment behaves as 0x800
    set_inc(12'hFFF, "R3");
    repeat (12) cyc("R3");
    // R5/R1: restart with 0x400
    en = 0; set_inc(12'h400, "R5");
    cyc("R4");
    en = 1;
    cyc("R5"); chk("R5", "no toggle yet", sck, 0);
    cyc("R5"); chk("R5", "first toggle on second edge", sck, 1);
    toggles = 0;
    for (int i = 0; i < 40; i++) begin
      cyc("R1");
      if (pri_edge || sec_edge) toggles++;
    end
    chk("R1", "toggles in 40 cycles", toggles, 20);
    // R6: polarity 1 with a slow rate
    en = 0; cpol = 1; set_inc(12'h155, "R6");
    repeat (3) cyc("R4");
    en = 1;
    repeat (60) cyc("R6");
    // R4: disable mid-run
    en = 0;
    repeat (5) cyc("R4");
    cpol = 0;
    // R12: 0x4CC half periods
    set_inc(12'h4CC, "R12");
    en = 1;
    last = 0; mx = 0; mn = 99; hp = 0; toggles = 0;
    for (int i = 0; i < 1000; i++) begin
      cyc("R12");
      hp++;
      if (pri_edge || sec_edge) begin
        if (toggles > 0) begin
          if (hp > mx) mx = hp;
          if (hp < mn) mn = hp;
        end
        toggles++; hp = 0;
      end
    end
    chk("R12", "max half period", mx, 2);
    chk("R12", "min half period", mn, 1);
    chk("R12", "toggles in 1000 cycles near 600", (toggles >= 598 && toggles <= 602) ? 1 : 0, 1);
    // R8: each legacy code
    for (int c = 0; c < 16; c++) begin
      spd_code = 4'(c); spd_wr = 1; cyc("R8");
      chk("R8", "table increment", inc_cur, table_inc(c));
      repeat (3) cyc("R8");
    end
    // R9: direct write leaves stale code
    set_inc(12'h123, "R9");
    chk("R9", "stale code", spd_code_q, 15);
    repeat (4) cyc("R9");
    // R10: both strobes together
    spd_code = 4'd5; spd_wr = 1; inc_in = 12'h7FF; inc_wr = 1; cyc("R10");
    chk("R10", "load wins", inc_cur, 41);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      en = (r < 95);
      if (r == 96) cpol = ~cpol;
      if ($urandom_range(0, 63) == 0) begin
        inc_in = 12'($urandom_range(0, 4095)); inc_wr = 1;
      end
      if ($urandom_range(0, 127) == 0) begin
        spd_code = 4'($urandom_range(0, 15)); spd_wr = 1;
      end
      cyc("R1");
    end
    finish_run();
  end
endmodule